// File: doc/BRIEF.md
# BCD calendar clock counter

This block keeps wall-clock time and calendar date as packed decimal digits. A two-stage prescaler divides the fast input clock into a 64 Hz pulse and then a once-per-second pulse. That pulse steps a seconds, minutes and hours chain, and the chain in turn steps a day, month, year and weekday chain. Each two-digit field is presented as one byte, with the tens digit in the upper nibble and the units digit in the lower nibble.

Hours count either 00 to 23 or 12, 1 to 11 with a PM flag, and the mode can be chosen at any time. February length follows the leap rule for a two-digit year. A bus block can load any single digit through a 4-bit select and data write port. Control inputs are provided to freeze counting, to clear the prescaler, and to round the time to the nearest minute. The carry pulses are available for other blocks, such as an interrupt generator.

Top module: `bcd_calendar_clock`

## Requirements
- R1: While rst_ni is low, seconds, minutes, hours and year read 00, day and month read 01, and the weekday reads 0.
- R2: hz64_o pulses for one cycle every PRE_DIV cycles and sec_tick_o every PRE_DIV*SUB_DIV cycles. After reset is released, the first sec_tick_o is high in cycle PRE_DIV*SUB_DIV-1, and the seconds value changes on the edge that ends that cycle.
- R3: While stop_i is high and pre_clr_i is low, the prescaler holds its count, hz64_o and sec_tick_o stay low, and the time does not change.
- R4: While pre_clr_i is high, both prescaler stages are held at zero and no pulse is produced. After release, the next sec_tick_o comes PRE_DIV*SUB_DIV-1 cycles later.
- R5: Seconds and minutes count 00 to 59 in BCD. min_carry_o is high in the cycle whose closing edge advances the minutes, and hour_carry_o is high in the cycle whose closing edge advances the hours.
- R6: With mode_24h_i high, hours count 00 to 23 in BCD, and the step from 23 to 00 advances the date.
- R7: With mode_24h_i low, hours run 12, 01, 02 ... 11. Bit 6 of hour_o is the PM flag (1 = PM), and bits 5:4 hold the hour tens. The flag toggles on the step from 11 to 12, and the step from 11 PM to 12 AM advances the date.
- R8: Day 01 follows the last day of the month. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year is divisible by 4 and 28 otherwise. All other months have 31 days. Month 12 rolls over to 01 and increments the year, and year 99 is followed by 00.
- R9: The weekday advances by one, modulo 7, each time the date advances.
- R10: A one-cycle pulse on adj30_i clears the seconds, whether or not counting is stopped. If the seconds tens digit was 3 or more, the minutes advance with a full carry into the hours and the date.
- R11: When wr_en_i is high, wr_sel_i selects the digit to load: 0 seconds units, 1 seconds tens, 2 minutes units, 3 minutes tens, 4 hours units, 5 hours tens (bit 2 = PM), 6 day units, 7 day tens, 8 month units, 9 month tens, 10 year units, 11 year tens, 12 weekday. Only the low bits that exist for that digit are stored: 3 bits for the seconds tens, minutes tens, hours tens and weekday, 2 bits for the day tens, 1 bit for the month tens, and 4 bits for all others.
- R12: In a cycle with wr_en_i high, no digit counts or carries. The write alone takes effect, even when a second pulse arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock (nominally 32.768 kHz) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Freeze prescaler and time counting |
| pre_clr_i | input | 1 | Clear both prescaler stages |
| mode_24h_i | input | 1 | 1 = 24-hour mode, 0 = 12-hour mode |
| adj30_i | input | 1 | Round to nearest minute (one-cycle pulse) |
| wr_en_i | input | 1 | Digit write strobe |
| wr_sel_i | input | 4 | Digit select for the write |
| wr_data_i | input | 4 | Digit value for the write |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD, bit 6 = PM |
| day_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |
| wday_o | output | 3 | Weekday 0 to 6 |
| hz64_o | output | 1 | 64 Hz stage pulse |
| sec_tick_o | output | 1 | Once-per-second pulse |
| min_carry_o | output | 1 | Minute advance pulse |
| hour_carry_o | output | 1 | Hour advance pulse |

## Verification
Several properties are checked on every clock cycle:
- Stop and clear really freeze or zero the prescaler.
- Every minute or hour carry leaves the lower fields at zero.
- Every date carry leaves the hour at midnight in either mode.
- The weekday moves whenever the date advances.
- A write to any other digit leaves the weekday untouched.

Other behaviour can only be shown by the directed scenarios:
- The exact cycle of the first second.
- The BCD digit carries.
- The 12-hour sequence with its PM flag.
- The month lengths and the leap-year rule.
- The year wrap.
- Both branches of the 30-second adjust.
- Write masking.
- A write that collides with a second pulse.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  typedef enum logic [3:0] {
    SEL_S1   = 4'd0,
    SEL_S10  = 4'd1,
    SEL_M1   = 4'd2,
    SEL_M10  = 4'd3,
    SEL_H1   = 4'd4,
    SEL_H10  = 4'd5,
    SEL_D1   = 4'd6,
    SEL_D10  = 4'd7,
    SEL_MO1  = 4'd8,
    SEL_MO10 = 4'd9,
    SEL_Y1   = 4'd10,
    SEL_Y10  = 4'd11,
    SEL_WK   = 4'd12
  } dsel_e;

  // two-digit BCD increment, no range limit
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // last day of month in BCD; year%4 == (2*tens + units)%4
  function automatic logic [7:0] month_last(input logic [7:0] mo, input logic [7:0] yr);
    logic [4:0] s;
    s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
    case (mo)
      8'h02:                      return (s[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int PRE_DIV = 512,
  parameter int SUB_DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  input  logic clr_i,
  output logic hz64_o,
  output logic tick_o
);
  localparam int AW = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam int BW = (SUB_DIV > 2) ? $clog2(SUB_DIV) : 1;
  localparam logic [AW-1:0] A_LAST = AW'(PRE_DIV - 1);
  localparam logic [BW-1:0] B_LAST = BW'(SUB_DIV - 1);

  logic [AW-1:0] cnt_a;
  logic [BW-1:0] cnt_b;
  logic run, a_last, b_last;

  assign run    = !stop_i && !clr_i;
  assign a_last = cnt_a == A_LAST;
  assign b_last = cnt_b == B_LAST;
  assign hz64_o = run && a_last;
  assign tick_o = run && a_last && b_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_a <= '0;
      cnt_b <= '0;
    end else if (clr_i) begin
      cnt_a <= '0;
      cnt_b <= '0;
    end else if (run) begin
      if (a_last) begin
        cnt_a <= '0;
        cnt_b <= b_last ? '0 : cnt_b + 1'b1;
      end else begin
        cnt_a <= cnt_a + 1'b1;
      end
    end
  end

  a_r3_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !clr_i) |=> ($stable(cnt_a) && $stable(cnt_b)));

  a_r4_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_a == '0 && cnt_b == '0));

endmodule

// File: rtl/cal_time_core.sv
module cal_time_core
  import bcd_cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       adj_i,
  input  logic       mode_24h_i,
  input  logic       wr_en_i,
  input  logic [3:0] wr_sel_i,
  input  logic [3:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       min_carry_o,
  output logic       hour_carry_o,
  output logic       day_carry_o
);
  logic [7:0] sec_q, min_q, hour_q;
  logic [7:0] hval, h_nx;
  logic       sec_wrap, min_wrap, adv_min, adv_hour;
  logic       pm, pm_nx, day_roll;

  assign sec_wrap = sec_q == 8'h59;
  assign min_wrap = min_q == 8'h59;
  // adjust rounds: tens >= 3 means 30..59 seconds
  assign adv_min  = adj_i ? (sec_q[7:4] >= 4'd3) : (tick_i && sec_wrap);
  assign adv_hour = adv_min && min_wrap;
  assign pm       = hour_q[6];
  assign hval     = {2'b00, hour_q[5:0]};

  always_comb begin
    h_nx     = bcd_inc(hval);
    pm_nx    = pm;
    day_roll = 1'b0;
    if (mode_24h_i) begin
      pm_nx = 1'b0;
      if (hval == 8'h23) begin
        h_nx     = 8'h00;
        day_roll = 1'b1;
      end
    end else if (hval == 8'h12) begin
      h_nx = 8'h01;
    end else if (hval == 8'h11) begin
      h_nx     = 8'h12;
      pm_nx    = !pm;
      day_roll = pm;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else if (wr_en_i) begin
      case (dsel_e'(wr_sel_i))
        SEL_S1:  sec_q[3:0]  <= wr_data_i;
        SEL_S10: sec_q[7:4]  <= {1'b0, wr_data_i[2:0]};
        SEL_M1:  min_q[3:0]  <= wr_data_i;
        SEL_M10: min_q[7:4]  <= {1'b0, wr_data_i[2:0]};
        SEL_H1:  hour_q[3:0] <= wr_data_i;
        SEL_H10: hour_q[7:4] <= {1'b0, wr_data_i[2:0]};
        default: ;
      endcase
    end else begin
      if (adj_i)       sec_q <= 8'h00;
      else if (tick_i) sec_q <= sec_wrap ? 8'h00 : bcd_inc(sec_q);
      if (adv_min)     min_q <= min_wrap ? 8'h00 : bcd_inc(min_q);
      if (adv_hour)    hour_q <= {1'b0, pm_nx, h_nx[5:0]};
    end
  end

  assign sec_o        = sec_q;
  assign min_o        = min_q;
  assign hour_o       = hour_q;
  assign min_carry_o  = adv_min && !wr_en_i;
  assign hour_carry_o = adv_hour && !wr_en_i;
  assign day_carry_o  = adv_hour && day_roll && !wr_en_i;

  a_r5_min_carry_zero_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_carry_o |=> sec_q == 8'h00);

  a_r5_hour_carry_zero_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hour_carry_o |=> (min_q == 8'h00 && sec_q == 8'h00));

  a_r7_day_carry_midnight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_carry_o |=> (hour_q == 8'h00 || hour_q == 8'h12));

endmodule

// File: rtl/cal_date_core.sv
module cal_date_core
  import bcd_cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       day_adv_i,
  input  logic       wr_en_i,
  input  logic [3:0] wr_sel_i,
  input  logic [3:0] wr_data_i,
  output logic [7:0] day_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic [2:0] wday_o
);
  logic [7:0] day_q, mon_q, year_q;
  logic [2:0] wday_q;
  logic       mon_end, year_end;

  assign mon_end  = day_q == month_last(mon_q, year_q);
  assign year_end = mon_q == 8'h12;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      day_q  <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 8'h00;
      wday_q <= 3'd0;
    end else if (wr_en_i) begin
      case (dsel_e'(wr_sel_i))
        SEL_D1:   day_q[3:0]  <= wr_data_i;
        SEL_D10:  day_q[7:4]  <= {2'b00, wr_data_i[1:0]};
        SEL_MO1:  mon_q[3:0]  <= wr_data_i;
        SEL_MO10: mon_q[7:4]  <= {3'b000, wr_data_i[0]};
        SEL_Y1:   year_q[3:0] <= wr_data_i;
        SEL_Y10:  year_q[7:4] <= wr_data_i;
        SEL_WK:   wday_q      <= wr_data_i[2:0];
        default: ;
      endcase
    end else if (day_adv_i) begin
      wday_q <= (wday_q >= 3'd6) ? 3'd0 : wday_q + 3'd1;
      if (mon_end) begin
        day_q <= 8'h01;
        if (year_end) begin
          mon_q  <= 8'h01;
          year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
        end else begin
          mon_q <= bcd_inc(mon_q);
        end
      end else begin
        day_q <= bcd_inc(day_q);
      end
    end
  end

  assign day_o   = day_q;
  assign month_o = mon_q;
  assign year_o  = year_q;
  assign wday_o  = wday_q;

  a_r9_wday_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_adv_i && !wr_en_i) |=> wday_q != $past(wday_q));

  a_r12_other_write_keeps_wday: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i != SEL_WK) |=> $stable(wday_q));

  a_r8_month_end_day_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_adv_i && !wr_en_i && mon_end) |=> day_q == 8'h01);

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock #(
  parameter int PRE_DIV = 512,
  parameter int SUB_DIV = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stop_i,
  input  logic       pre_clr_i,
  input  logic       mode_24h_i,
  input  logic       adj30_i,
  input  logic       wr_en_i,
  input  logic [3:0] wr_sel_i,
  input  logic [3:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] day_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic [2:0] wday_o,
  output logic       hz64_o,
  output logic       sec_tick_o,
  output logic       min_carry_o,
  output logic       hour_carry_o
);
  logic tick, day_adv;

  cal_prescaler #(
    .PRE_DIV(PRE_DIV),
    .SUB_DIV(SUB_DIV)
  ) i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stop_i (stop_i),
    .clr_i  (pre_clr_i),
    .hz64_o (hz64_o),
    .tick_o (tick)
  );

  cal_time_core i_time (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .adj_i        (adj30_i),
    .mode_24h_i   (mode_24h_i),
    .wr_en_i      (wr_en_i),
    .wr_sel_i     (wr_sel_i),
    .wr_data_i    (wr_data_i),
    .sec_o        (sec_o),
    .min_o        (min_o),
    .hour_o       (hour_o),
    .min_carry_o  (min_carry_o),
    .hour_carry_o (hour_carry_o),
    .day_carry_o  (day_adv)
  );

  cal_date_core i_date (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .day_adv_i (day_adv),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .day_o     (day_o),
    .month_o   (month_o),
    .year_o    (year_o),
    .wday_o    (wday_o)
  );

  assign sec_tick_o = tick;

endmodule

// File: tb/test_bcd_calendar_clock.sv
`timescale 1ns/1ps
module test_bcd_calendar_clock;
  localparam int PRE = 2;
  localparam int SUB = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic stop = 1'b0, pre_clr = 1'b0, mode24 = 1'b1, adj = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_sel = '0, wr_data = '0;
  logic [7:0] sec_o, min_o, hour_o, day_o, month_o, year_o;
  logic [2:0] wday_o;
  logic hz64_o, sec_tick_o, min_carry_o, hour_carry_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic cap_min, cap_hour;

  always #2.5 clk = ~clk;

  bcd_calendar_clock #(.PRE_DIV(PRE), .SUB_DIV(SUB)) i_bcd_calendar_clock (
    .clk_i(clk), .rst_ni(rst_ni), .stop_i(stop), .pre_clr_i(pre_clr),
    .mode_24h_i(mode24), .adj30_i(adj), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .day_o(day_o), .month_o(month_o), .year_o(year_o), .wday_o(wday_o),
    .hz64_o(hz64_o), .sec_tick_o(sec_tick_o), .min_carry_o(min_carry_o),
    .hour_carry_o(hour_carry_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic load(input logic [3:0] sel, input logic [3:0] val);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_clock(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    load(4'd0, s[3:0]); load(4'd1, s[7:4]);
    load(4'd2, m[3:0]); load(4'd3, m[7:4]);
    load(4'd4, h[3:0]); load(4'd5, h[7:4]);
  endtask

  task automatic set_date(input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y, input logic [3:0] wd);
    load(4'd6, d[3:0]);  load(4'd7, d[7:4]);
    load(4'd8, mo[3:0]); load(4'd9, mo[7:4]);
    load(4'd10, y[3:0]); load(4'd11, y[7:4]);
    load(4'd12, wd);
  endtask

  // run until one second pulse is consumed, then freeze again
  task automatic step_second();
    stop = 1'b0;
    #1;
    while (!sec_tick_o) @(negedge clk);
    cap_min = min_carry_o; cap_hour = hour_carry_o;
    @(negedge clk);
    stop = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1", "sec", sec_o, 8'h00);   chk("R1", "min", min_o, 8'h00);
    chk("R1", "hour", hour_o, 8'h00); chk("R1", "day", day_o, 8'h01);
    chk("R1", "month", month_o, 8'h01); chk("R1", "year", year_o, 8'h00);
    chk("R1", "wday", wday_o, 3'd0);
  endtask

  task automatic t_prescale();
    @(negedge clk);
    chk("R2", "hz64 after 1 edge", hz64_o, 1'b1);
    @(negedge clk);
    chk("R2", "hz64 after 2 edges", hz64_o, 1'b0);
    repeat (5) @(negedge clk);
    chk("R2", "tick at cycle 7", sec_tick_o, 1'b1);
    chk("R2", "sec before edge 8", sec_o, 8'h00);
    @(negedge clk);
    chk("R2", "sec after edge 8", sec_o, 8'h01);
    chk("R2", "tick after edge 8", sec_tick_o, 1'b0);
  endtask

  task automatic t_stop();
    logic [7:0] s0;
    int seen = 0;
    stop = 1'b1;
    s0 = sec_o;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (hz64_o || sec_tick_o || sec_o != s0) seen++;
    end
    chk("R3", "activity while stopped", seen, 0);
  endtask

  task automatic t_clear();
    logic [7:0] s0;
    int seen = 0;
    stop = 1'b0; pre_clr = 1'b1;
    s0 = sec_o;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (hz64_o || sec_tick_o || sec_o != s0) seen++;
    end
    chk("R4", "activity while cleared", seen, 0);
    pre_clr = 1'b0;
    repeat (7) @(negedge clk);
    chk("R4", "tick 7 cycles after clear", sec_tick_o, 1'b1);
    @(negedge clk);
    chk("R4", "sec advanced after clear", sec_o, 8'(s0 + 8'd1));
    stop = 1'b1;
  endtask

  task automatic t_sec_min();
    mode24 = 1'b1;
    set_clock(8'h00, 8'h09, 8'h58);
    step_second();
    chk("R5", "sec 58->59", sec_o, 8'h59);
    chk("R5", "no min carry at 58", cap_min, 1'b0);
    step_second();
    chk("R5", "sec wraps", sec_o, 8'h00);
    chk("R5", "min 09->10", min_o, 8'h10);
    chk("R5", "min carry pulse", cap_min, 1'b1);
    set_clock(8'h09, 8'h59, 8'h59);
    step_second();
    chk("R5", "hour carry pulse", cap_hour, 1'b1);
    chk("R6", "hour 09->10", hour_o, 8'h10);
    chk("R5", "min wraps", min_o, 8'h00);
  endtask

  task automatic t_24h();
    mode24 = 1'b1;
    set_date(8'h14, 8'h05, 8'h23, 4'd3);
    set_clock(8'h23, 8'h59, 8'h59);
    step_second();
    chk("R6", "hour 23->00", hour_o, 8'h00);
    chk("R6", "day advanced", day_o, 8'h15);
    chk("R9", "wday 3->4", wday_o, 3'd4);
  endtask

  task automatic t_12h();
    mode24 = 1'b0;
    set_date(8'h10, 8'h03, 8'h21, 4'd1);
    set_clock(8'h11, 8'h59, 8'h59);
    step_second();
    chk("R7", "11 AM -> 12 PM", hour_o, 8'h52);
    chk("R7", "day kept at noon", day_o, 8'h10);
    set_clock(8'h52, 8'h59, 8'h59);
    step_second();
    chk("R7", "12 PM -> 1 PM", hour_o, 8'h41);
    set_clock(8'h51, 8'h59, 8'h59);
    step_second();
    chk("R7", "11 PM -> 12 AM", hour_o, 8'h12);
    chk("R7", "day at midnight", day_o, 8'h11);
    chk("R9", "wday 1->2", wday_o, 3'd2);
    mode24 = 1'b1;
  endtask

  task automatic roll_day(input string req, input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y,
                          input logic [3:0] wd, input logic [7:0] ed, input logic [7:0] emo,
                          input logic [7:0] ey, input logic [2:0] ewd);
    set_date(d, mo, y, wd);
    set_clock(8'h23, 8'h59, 8'h59);
    step_second();
    chk(req, "day", day_o, ed);
    chk(req, "month", month_o, emo);
    chk(req, "year", year_o, ey);
    chk("R9", "wday", wday_o, ewd);
  endtask

  task automatic t_months();
    mode24 = 1'b1;
    roll_day("R8", 8'h31, 8'h01, 8'h23, 4'd2, 8'h01, 8'h02, 8'h23, 3'd3);
    roll_day("R8", 8'h30, 8'h04, 8'h23, 4'd0, 8'h01, 8'h05, 8'h23, 3'd1);
    roll_day("R8", 8'h30, 8'h05, 8'h23, 4'd4, 8'h31, 8'h05, 8'h23, 3'd5);
    roll_day("R8", 8'h28, 8'h02, 8'h23, 4'd5, 8'h01, 8'h03, 8'h23, 3'd6);
    roll_day("R8", 8'h28, 8'h02, 8'h24, 4'd6, 8'h29, 8'h02, 8'h24, 3'd0);
    roll_day("R8", 8'h29, 8'h02, 8'h24, 4'd0, 8'h01, 8'h03, 8'h24, 3'd1);
    roll_day("R8", 8'h28, 8'h02, 8'h00, 4'd2, 8'h29, 8'h02, 8'h00, 3'd3);
    roll_day("R8", 8'h31, 8'h12, 8'h99, 4'd6, 8'h01, 8'h01, 8'h00, 3'd0);
    roll_day("R8", 8'h31, 8'h12, 8'h19, 4'd1, 8'h01, 8'h01, 8'h20, 3'd2);
  endtask

  task automatic t_adjust();
    stop = 1'b1;
    set_clock(8'h08, 8'h07, 8'h29);
    adj = 1'b1; #1;
    cap_min = min_carry_o;
    @(negedge clk); adj = 1'b0;
    chk("R10", "sec cleared below 30", sec_o, 8'h00);
    chk("R10", "min kept below 30", min_o, 8'h07);
    chk("R10", "no carry below 30", cap_min, 1'b0);
    set_clock(8'h08, 8'h07, 8'h45);
    adj = 1'b1; #1;
    cap_min = min_carry_o;
    @(negedge clk); adj = 1'b0;
    chk("R10", "sec cleared at 45", sec_o, 8'h00);
    chk("R10", "min rounded up", min_o, 8'h08);
    chk("R10", "carry at 45", cap_min, 1'b1);
    set_date(8'h30, 8'h06, 8'h22, 4'd2);
    set_clock(8'h23, 8'h59, 8'h30);
    adj = 1'b1;
    @(negedge clk); adj = 1'b0;
    chk("R10", "full carry hour", hour_o, 8'h00);
    chk("R10", "full carry min", min_o, 8'h00);
    chk("R10", "full carry day", day_o, 8'h01);
    chk("R10", "full carry month", month_o, 8'h07);
  endtask

  task automatic t_write();
    stop = 1'b1;
    load(4'd1, 4'hF);
    chk("R11", "sec tens masked to 3 bits", sec_o[7:4], 4'h7);
    load(4'd9, 4'hF);
    chk("R11", "month tens masked to 1 bit", month_o[7:4], 4'h1);
    load(4'd7, 4'hE);
    chk("R11", "day tens masked to 2 bits", day_o[7:4], 4'h2);
    load(4'd12, 4'd5);
    chk("R11", "weekday load", wday_o, 3'd5);
    load(4'd10, 4'd7); load(4'd11, 4'd4);
    chk("R11", "year load", year_o, 8'h47);
  endtask

  task automatic t_collide();
    mode24 = 1'b1;
    set_clock(8'h05, 8'h10, 8'h59);
    stop = 1'b0;
    #1;
    while (!sec_tick_o) @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'd0; wr_data = 4'd3;
    #1;
    cap_min = min_carry_o;
    @(negedge clk);
    wr_en = 1'b0; stop = 1'b1;
    chk("R12", "write wins over tick", sec_o, 8'h53);
    chk("R12", "no minute advance", min_o, 8'h10);
    chk("R12", "no carry during write", cap_min, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_prescale();
    t_stop();
    t_clear();
    t_sec_min();
    t_24h();
    t_12h();
    t_months();
    t_adjust();
    t_write();
    t_collide();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

endmodule